// File: doc/BRIEF.md
# Residue-Tracking Edit-Distance Counter

This block sits behind the last processing element of a systolic array that computes edit distance. To save area, the array carries only a 2-bit value modulo 4 for each intermediate distance. Between neighbouring cells, successive values of that distance differ by exactly one. Each time the last column emits a residue, the block compares it with the residue it saw before. It then moves a 32-bit count one step up or one step down. In this way the true integer distance is rebuilt from a stream of small wrapped values.

A start pulse marks the beginning of each database sequence and loads the count with the number of processing elements. The first residue after that pulse only sets the reference value. An end-of-sequence flag on the final residue raises a one-cycle done strobe, and the finished distance is shown on the result port at that time. A residue that does not differ by plus or minus one from the previous residue cannot come from a correct array. Such a residue is reported on an error strobe and has no effect on the count.

Top module: `edit_dist_tracker`

## Requirements
- R1: After reset the result equals PE_COUNT and done and error are low. The block is idle: valid residues are ignored until a start pulse arrives.
- R2: A start pulse sets the result to PE_COUNT on the next cycle and arms the block for a new sequence. A residue that is valid in the same cycle as start is ignored.
- R3: The first valid residue after a start becomes the reference value and leaves the result unchanged.
- R4: When a valid residue equals the reference plus one modulo 4 (0→1, 1→2, 2→3, 3→0), the result increases by one on the next cycle.
- R5: When a valid residue equals the reference minus one modulo 4 (3→2, 2→1, 1→0, 0→3), the result decreases by one on the next cycle.
- R6: When a valid residue equals the reference, or differs from it by two, the error output is high for exactly one cycle on the next cycle and the result does not change. In every case the new residue becomes the reference.
- R7: In a cycle with no valid residue and no start, the result holds its value.
- R8: A valid residue that arrives with end-of-sequence gives a done pulse of exactly one cycle on the next cycle. At that time the result already includes that residue's step. The block then returns to idle and ignores residues until the next start.
- R9: The result wraps modulo 2^32: one step down from 0 gives 0xFFFFFFFF, and one step up from there gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Preset the count and arm for a new sequence |
| res_valid_i | input | 1 | Residue input is valid this cycle |
| res_i | input | RES_W (2) | Distance residue from the last column, modulo 4 |
| last_i | input | 1 | Marks the valid residue as the last of the sequence |
| dist_o | output | CNT_W (32) | Reconstructed edit distance |
| done_o | output | 1 | One-cycle pulse when the final distance is shown |
| err_o | output | 1 | One-cycle pulse for an inconsistent residue step |

## Verification
A stale or corrupted reference residue gives the wrong step direction, or a false error pulse, on the very next valid residue. It therefore appears on `dist_o` or `err_o` one cycle after the offending input. A control state that is stuck or wrong shows up as residues being counted while the block should be idle, as a missing or repeated `done_o`, or as the first residue moving the count. Each of these is visible at the ports in the cycle after the input that exposes it. Counter faults in the width or the wrap only become visible at the underflow boundary, so that boundary is exercised directly.

// File: rtl/edt_pkg.sv
package edt_pkg;

    // classification of one residue transition
    typedef enum logic [1:0] {
        STEP_UP  = 2'd0,
        STEP_DN  = 2'd1,
        STEP_BAD = 2'd2
    } edt_step_e;

    // sequencing phase of the tracker
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FIRST = 2'd1,
        PH_RUN   = 2'd2
    } edt_phase_e;

endpackage

// File: rtl/edt_step_decode.sv
module edt_step_decode
    import edt_pkg::*;
#(
    parameter int RES_W = 2
) (
    input  logic [RES_W-1:0] prev_i,
    input  logic [RES_W-1:0] cur_i,
    output edt_step_e        step_o
);

    localparam logic [RES_W-1:0] FWD_DIFF = RES_W'(1);
    localparam logic [RES_W-1:0] BWD_DIFF = {RES_W{1'b1}};

    logic [RES_W-1:0] diff;

    always_comb begin
        diff = cur_i - prev_i;
        if (diff == FWD_DIFF) begin
            step_o = STEP_UP;
        end else if (diff == BWD_DIFF) begin
            step_o = STEP_DN;
        end else begin
            step_o = STEP_BAD;
        end
    end

endmodule

// File: rtl/edt_counter.sv
module edt_counter #(
    parameter int CNT_W    = 32,
    parameter int PE_COUNT = 3026
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] PRESET = CNT_W'(PE_COUNT);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = PRESET;
        end else if (inc_i) begin
            cnt_d = cnt_q + ONE;
        end else if (dec_i) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= PRESET;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/edt_ctrl.sv
module edt_ctrl
    import edt_pkg::*;
#(
    parameter int RES_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             valid_i,
    input  logic             last_i,
    input  logic [RES_W-1:0] res_i,
    input  edt_step_e        step_i,
    output logic [RES_W-1:0] prev_o,
    output logic             load_o,
    output logic             inc_o,
    output logic             dec_o,
    output logic             done_o,
    output logic             err_o
);

    typedef struct packed {
        edt_phase_e       phase;
        logic [RES_W-1:0] prev;
        logic             done;
        logic             err;
    } ctrl_s;

    ctrl_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        load_o    = 1'b0;
        inc_o     = 1'b0;
        dec_o     = 1'b0;

        if (start_i) begin
            load_o     = 1'b1;
            st_d.phase = PH_FIRST;
        end else if (valid_i) begin
            unique case (st_q.phase)
                PH_FIRST: begin
                    st_d.prev  = res_i;
                    st_d.done  = last_i;
                    st_d.phase = last_i ? PH_IDLE : PH_RUN;
                end
                PH_RUN: begin
                    st_d.prev = res_i;
                    unique case (step_i)
                        STEP_UP:  inc_o    = 1'b1;
                        STEP_DN:  dec_o    = 1'b1;
                        default:  st_d.err = 1'b1;
                    endcase
                    st_d.done  = last_i;
                    st_d.phase = last_i ? PH_IDLE : PH_RUN;
                end
                default: begin
                    st_d = st_d;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, prev: '0, done: 1'b0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign prev_o = st_q.prev;
    assign done_o = st_q.done;
    assign err_o  = st_q.err;

endmodule

// File: rtl/edit_dist_tracker.sv
module edit_dist_tracker
    import edt_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int RES_W    = 2,
    parameter int PE_COUNT = 3026
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             res_valid_i,
    input  logic [RES_W-1:0] res_i,
    input  logic             last_i,
    output logic [CNT_W-1:0] dist_o,
    output logic             done_o,
    output logic             err_o
);

    logic [RES_W-1:0] prev_res;
    edt_step_e        step;
    logic             cnt_load, cnt_inc, cnt_dec;

    edt_step_decode #(.RES_W(RES_W)) u_decode (
        .prev_i (prev_res),
        .cur_i  (res_i),
        .step_o (step)
    );

    edt_ctrl #(.RES_W(RES_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .valid_i (res_valid_i),
        .last_i  (last_i),
        .res_i   (res_i),
        .step_i  (step),
        .prev_o  (prev_res),
        .load_o  (cnt_load),
        .inc_o   (cnt_inc),
        .dec_o   (cnt_dec),
        .done_o  (done_o),
        .err_o   (err_o)
    );

    edt_counter #(.CNT_W(CNT_W), .PE_COUNT(PE_COUNT)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cnt_load),
        .inc_i  (cnt_inc),
        .dec_i  (cnt_dec),
        .cnt_o  (dist_o)
    );

endmodule

// File: rtl/edt_chk.sv
module edt_chk #(
    parameter int CNT_W    = 32,
    parameter int RES_W    = 2,
    parameter int PE_COUNT = 3026
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             res_valid_i,
    input logic [RES_W-1:0] res_i,
    input logic             last_i,
    input logic [CNT_W-1:0] dist_o,
    input logic             done_o,
    input logic             err_o
);

    localparam logic [CNT_W-1:0] PRESET = CNT_W'(PE_COUNT);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    // R2
    preset_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (dist_o == PRESET));

    // R7
    hold_when_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !res_valid_i) |=> $stable(dist_o));

    // R4
    unit_step_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i) |=> (dist_o == $past(dist_o) || dist_o == $past(dist_o) + ONE
                        || dist_o == $past(dist_o) - ONE));

    // R6
    err_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $stable(dist_o));

    // R8
    done_needs_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(res_valid_i && last_i && !start_i));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(res_valid_i && !start_i));

    logic unused_res;
    assign unused_res = ^res_i;

endmodule

bind edit_dist_tracker edt_chk #(
    .CNT_W(CNT_W), .RES_W(RES_W), .PE_COUNT(PE_COUNT)
) u_edt_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .res_valid_i (res_valid_i),
    .res_i       (res_i),
    .last_i      (last_i),
    .dist_o      (dist_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/tb_edit_dist_tracker.sv
`timescale 1ns/1ps
module tb_edit_dist_tracker;

    localparam int P = 3026;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        res_valid_i = 1'b0;
    logic [1:0]  res_i = 2'd0;
    logic        last_i = 1'b0;
    logic [31:0] dist_o;
    logic        done_o, err_o;

    int checks = 0;
    int fails  = 0;
    bit summary_done = 1'b0;

    always #10 clk = ~clk;

    edit_dist_tracker #(.CNT_W(32), .RES_W(2), .PE_COUNT(P)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .res_valid_i(res_valid_i),
        .res_i(res_i), .last_i(last_i), .dist_o(dist_o), .done_o(done_o), .err_o(err_o)
    );

    typedef struct packed {
        logic        st;
        logic        v;
        logic        l;
        logic [1:0]  r;
        logic [31:0] exp_d;
        logic        exp_e;
        logic        exp_f;
    } row_t;

    localparam int NROWS = 17;
    localparam row_t TBL [NROWS] = '{
        '{1'b1, 1'b0, 1'b0, 2'd0, 32'(P),   1'b0, 1'b0}, // R2 start
        '{1'b0, 1'b1, 1'b0, 2'd0, 32'(P),   1'b0, 1'b0}, // R3 first residue
        '{1'b0, 1'b1, 1'b0, 2'd1, 32'(P+1), 1'b0, 1'b0}, // R4 0->1
        '{1'b0, 1'b1, 1'b0, 2'd2, 32'(P+2), 1'b0, 1'b0}, // R4 1->2
        '{1'b0, 1'b1, 1'b0, 2'd3, 32'(P+3), 1'b0, 1'b0}, // R4 2->3
        '{1'b0, 1'b1, 1'b0, 2'd0, 32'(P+4), 1'b0, 1'b0}, // R4 wrap 3->0
        '{1'b0, 1'b1, 1'b0, 2'd3, 32'(P+3), 1'b0, 1'b0}, // R5 wrap 0->3
        '{1'b0, 1'b1, 1'b0, 2'd2, 32'(P+2), 1'b0, 1'b0}, // R5 3->2
        '{1'b0, 1'b0, 1'b0, 2'd1, 32'(P+2), 1'b0, 1'b0}, // R7 no valid
        '{1'b0, 1'b1, 1'b0, 2'd2, 32'(P+2), 1'b1, 1'b0}, // R6 same residue
        '{1'b0, 1'b1, 1'b0, 2'd0, 32'(P+2), 1'b1, 1'b0}, // R6 differ by 2
        '{1'b0, 1'b1, 1'b0, 2'd1, 32'(P+3), 1'b0, 1'b0}, // R6 ref updated, R4
        '{1'b0, 1'b1, 1'b1, 2'd2, 32'(P+4), 1'b0, 1'b1}, // R8 last
        '{1'b0, 1'b1, 1'b0, 2'd3, 32'(P+4), 1'b0, 1'b0}, // R8 idle ignores
        '{1'b1, 1'b1, 1'b0, 2'd1, 32'(P),   1'b0, 1'b0}, // R2 start wins
        '{1'b0, 1'b1, 1'b0, 2'd3, 32'(P),   1'b0, 1'b0}, // R3 first residue
        '{1'b0, 1'b1, 1'b1, 2'd0, 32'(P+1), 1'b0, 1'b1}  // R8 with R4 step
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic step(input logic st, input logic v, input logic l, input logic [1:0] r);
        @(negedge clk);
        start_i = st; res_valid_i = v; last_i = l; res_i = r;
        @(posedge clk);
        #1;
        @(negedge clk);
        start_i = 1'b0; res_valid_i = 1'b0; last_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20.0 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [1:0] r;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 dist in reset", dist_o, 32'(P));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 dist after reset", dist_o, 32'(P));
        chk("R1 done after reset", {31'd0, done_o}, 32'd0);
        chk("R1 err after reset", {31'd0, err_o}, 32'd0);
        step(1'b0, 1'b1, 1'b0, 2'd1);
        step(1'b0, 1'b1, 1'b0, 2'd2);
        chk("R1 residues ignored while idle", dist_o, 32'(P));

        // table walk
        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            start_i = TBL[i].st; res_valid_i = TBL[i].v;
            last_i = TBL[i].l; res_i = TBL[i].r;
            @(posedge clk);
            #1;
            chk($sformatf("row%0d dist (R2..R8)", i), dist_o, TBL[i].exp_d);
            chk($sformatf("row%0d err R6", i), {31'd0, err_o}, {31'd0, TBL[i].exp_e});
            chk($sformatf("row%0d done R8", i), {31'd0, done_o}, {31'd0, TBL[i].exp_f});
        end
        @(negedge clk);
        start_i = 1'b0; res_valid_i = 1'b0; last_i = 1'b0;
        @(posedge clk);
        #1;
        chk("R8 done lasts one cycle", {31'd0, done_o}, 32'd0);
        chk("R6 err lasts one cycle", {31'd0, err_o}, 32'd0);

        // R8 last on the first residue
        step(1'b1, 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        start_i = 1'b0; res_valid_i = 1'b1; last_i = 1'b1; res_i = 2'd2;
        @(posedge clk);
        #1;
        chk("R8 done on first residue", {31'd0, done_o}, 32'd1);
        chk("R8 R3 dist on first residue", dist_o, 32'(P));

        // R9 underflow wrap
        step(1'b1, 1'b0, 1'b0, 2'd0);
        step(1'b0, 1'b1, 1'b0, 2'd0);
        r = 2'd0;
        for (int k = 0; k < P + 1; k++) begin
            r = r - 2'd1;
            step(1'b0, 1'b1, 1'b0, r);
        end
        chk("R9 wrap below zero", dist_o, 32'hFFFF_FFFF);
        r = r + 2'd1;
        step(1'b0, 1'b1, 1'b0, r);
        chk("R9 wrap back to zero", dist_o, 32'd0);

        // R1 reset mid-run returns to idle preset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 mid-run reset dist", dist_o, 32'(P));
        step(1'b0, 1'b1, 1'b0, 2'd0);
        step(1'b0, 1'b1, 1'b0, 2'd1);
        chk("R1 idle after mid-run reset", dist_o, 32'(P));
        chk("R1 no error while idle", {31'd0, err_o}, 32'd0);

        finish_run();
    end

endmodule